// File: doc/BRIEF.md
# Bit Manipulation Execution Unit

This unit is the bit-manipulation slice of a 32-bit integer execute stage. Each cycle it can accept one operation. An operation is made of two source operands, a 2-bit scale value for the shift-and-add group and a 5-bit operation code. The result is computed combinationally from those inputs. It then enters an output register, so the answer and its valid flag appear one clock after the input was presented.

The unit covers these groups: shift-and-add, logic ops with an inverted second operand, leading and trailing zero counts, population count, signed and unsigned minimum and maximum, byte and halfword extension, rotates, byte OR-combine, byte reverse, and single-bit clear, set, invert and extract. Decode, operand forwarding and hazard handling belong to the surrounding pipeline. An operation code outside the table yields zero.

Top module: `bitmanip_unit`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the previous rising edge. Reset (active-low `rst_n`) clears `out_valid` and `result` to zero.
- R2: While `in_valid` is low, `result` keeps its last value, even when the operand or code inputs change.
- R3: Code 0 (scaled add) returns `rs2 + (rs1 << scale)`, where `scale` is the 2-bit input, modulo 2^32.
- R4: Code 1 returns `rs1 & ~rs2`, code 2 returns `rs1 | ~rs2` and code 3 returns `~(rs1 ^ rs2)`.
- R5: Code 4 counts leading zeros and code 5 counts trailing zeros. Both return 32 for a zero operand. Code 6 returns the number of ones in `rs1`, from 0 to 32.
- R6: Code 7 gives the signed minimum and code 8 the signed maximum, in two's complement. Code 9 gives the unsigned minimum and code 10 the unsigned maximum, comparing all 32 bits as magnitudes.
- R7: Code 11 copies bit 7 into bits 31..8, and code 12 copies bit 15 into bits 31..16. Code 13 clears bits 31..16.
- R8: Code 14 rotates `rs1` left and code 15 rotates it right, by the amount in `rs2`. An amount of zero returns `rs1` unchanged.
- R9: Code 16 writes 0xFF to each result byte whose input byte is nonzero and 0x00 to the others. Code 17 reverses byte order: input byte 0 goes to byte 3, byte 1 to byte 2, byte 2 to byte 1 and byte 3 to byte 0.
- R10: Code 18 clears bit `rs2` of `rs1`, code 19 sets it and code 20 inverts it. Code 21 returns that bit in bit 0 with all other bits zero.
- R11: Rotates and single-bit operations use only `rs2[4:0]`, so an amount or index of 32+n acts as n.
- R12: Codes 22 to 31 produce a zero result, and `out_valid` still follows `in_valid` as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 5 | Operation code |
| rs1 | input | 32 | First source operand |
| rs2 | input | 32 | Second source operand, amount or bit index |
| scale | input | 2 | Shift of `rs1` for the scaled add |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 32 | Registered result |

## Verification
The count group is swept with a run of ones growing from one end of the word, so every count from 0 to 32 is seen, including the all-zero and all-one operands. Rotates and bit operations are swept over every index 0 to 31, and indices with upper bits set then show whether only the low five bits are decoded. Min and max get random pairs plus the pair 0x80000000 / 0x7FFFFFFF, which gives opposite answers in the signed and unsigned forms. The byte operations use operands in which whole bytes are randomly zeroed. Idle cycles with changing inputs, back-to-back operations and all unused codes cover the output register.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_SCADD = 5'd0,
    OP_ANDI  = 5'd1,
    OP_ORI   = 5'd2,
    OP_XNOR  = 5'd3,
    OP_LZC   = 5'd4,
    OP_TZC   = 5'd5,
    OP_POP   = 5'd6,
    OP_MIN   = 5'd7,
    OP_MAX   = 5'd8,
    OP_MINU  = 5'd9,
    OP_MAXU  = 5'd10,
    OP_SXB   = 5'd11,
    OP_SXH   = 5'd12,
    OP_ZXH   = 5'd13,
    OP_ROTL  = 5'd14,
    OP_ROTR  = 5'd15,
    OP_BYOR  = 5'd16,
    OP_BYREV = 5'd17,
    OP_BCLR  = 5'd18,
    OP_BSET  = 5'd19,
    OP_BFLIP = 5'd20,
    OP_BGET  = 5'd21
  } bmu_op_e;

  localparam int NUM_OPS = 22;
endpackage

// File: rtl/bmu_arith.sv
module bmu_arith
  import bmu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [1:0]      scale,
  output logic [XLEN-1:0] res
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = XLEN / 2;

  function automatic logic [XLEN-1:0] f_pick(input logic [XLEN-1:0] x,
                                             input logic [XLEN-1:0] y,
                                             input logic is_signed,
                                             input logic want_max);
    logic x_lt_y;
    if (is_signed) x_lt_y = $signed(x) < $signed(y);
    else           x_lt_y = x < y;
    return (x_lt_y ^ want_max) ? x : y;
  endfunction

  function automatic logic [XLEN-1:0] f_sext(input logic [XLEN-1:0] x,
                                             input int unsigned width);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = (i < width) ? x[i] : x[width-1];
    return r;
  endfunction

  logic [XLEN-1:0] scaled_sum;
  logic [XLEN-1:0] minmax_res;
  logic [XLEN-1:0] zx_half;

  assign scaled_sum = b + (a << scale);
  assign zx_half    = {{(XLEN-HALF_W){1'b0}}, a[HALF_W-1:0]};

  always_comb begin
    case (op)
      OP_MIN:  minmax_res = f_pick(a, b, 1'b1, 1'b0);
      OP_MAX:  minmax_res = f_pick(a, b, 1'b1, 1'b1);
      OP_MINU: minmax_res = f_pick(a, b, 1'b0, 1'b0);
      default: minmax_res = f_pick(a, b, 1'b0, 1'b1);
    endcase
  end

  always_comb begin
    case (op)
      OP_SCADD: res = scaled_sum;
      OP_ANDI:  res = a & ~b;
      OP_ORI:   res = a | ~b;
      OP_XNOR:  res = ~(a ^ b);
      OP_MIN, OP_MAX, OP_MINU, OP_MAXU: res = minmax_res;
      OP_SXB:   res = f_sext(a, BYTE_W);
      OP_SXH:   res = f_sext(a, HALF_W);
      OP_ZXH:   res = zx_half;
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/bmu_count.sv
module bmu_count #(
  parameter int XLEN = 32,
  localparam int CNT_W = $clog2(XLEN) + 1
) (
  input  logic [XLEN-1:0]  a,
  output logic [CNT_W-1:0] lead_zeros,
  output logic [CNT_W-1:0] trail_zeros,
  output logic [CNT_W-1:0] ones
);
  function automatic logic [CNT_W-1:0] f_lead(input logic [XLEN-1:0] x);
    logic [CNT_W-1:0] n;
    logic seen;
    n = '0;
    seen = 1'b0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      seen = seen | x[i];
      if (!seen) n = n + 1'b1;
    end
    return n;
  endfunction

  function automatic logic [CNT_W-1:0] f_trail(input logic [XLEN-1:0] x);
    logic [CNT_W-1:0] n;
    logic seen;
    n = '0;
    seen = 1'b0;
    for (int i = 0; i < XLEN; i++) begin
      seen = seen | x[i];
      if (!seen) n = n + 1'b1;
    end
    return n;
  endfunction

  function automatic logic [CNT_W-1:0] f_ones(input logic [XLEN-1:0] x);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < XLEN; i++) n = n + {{(CNT_W-1){1'b0}}, x[i]};
    return n;
  endfunction

  assign lead_zeros  = f_lead(a);
  assign trail_zeros = f_trail(a);
  assign ones        = f_ones(a);
endmodule

// File: rtl/bmu_bitpos.sv
module bmu_bitpos #(
  parameter int XLEN = 32,
  localparam int IDX_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  a,
  input  logic [IDX_W-1:0] idx,
  output logic [XLEN-1:0]  rot_l,
  output logic [XLEN-1:0]  rot_r,
  output logic [XLEN-1:0]  bit_clr,
  output logic [XLEN-1:0]  bit_set,
  output logic [XLEN-1:0]  bit_flip,
  output logic [XLEN-1:0]  bit_get
);
  logic [2*XLEN-1:0] dbl_l;
  logic [2*XLEN-1:0] dbl_r;
  logic [XLEN-1:0]   onehot;

  assign dbl_l = {a, a} << idx;
  assign dbl_r = {a, a} >> idx;
  assign rot_l = dbl_l[2*XLEN-1:XLEN];
  assign rot_r = dbl_r[XLEN-1:0];

  assign onehot   = {{(XLEN-1){1'b0}}, 1'b1} << idx;
  assign bit_clr  = a & ~onehot;
  assign bit_set  = a | onehot;
  assign bit_flip = a ^ onehot;
  assign bit_get  = {{(XLEN-1){1'b0}}, a[idx]};
endmodule

// File: rtl/bmu_bytes.sv
module bmu_bytes #(
  parameter int XLEN = 32,
  localparam int NBYTES = XLEN / 8
) (
  input  logic [XLEN-1:0] a,
  output logic [XLEN-1:0] or_comb,
  output logic [XLEN-1:0] reversed
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign or_comb[8*g +: 8]  = {8{|a[8*g +: 8]}};
    assign reversed[8*g +: 8] = a[8*(NBYTES-1-g) +: 8];
  end
endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
  import bmu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [4:0]      op,
  input  logic [XLEN-1:0] rs1,
  input  logic [XLEN-1:0] rs2,
  input  logic [1:0]      scale,
  output logic            out_valid,
  output logic [XLEN-1:0] result
);
  localparam int IDX_W = $clog2(XLEN);
  localparam int CNT_W = IDX_W + 1;

  logic [XLEN-1:0]  arith_res;
  logic [CNT_W-1:0] lead_zeros, trail_zeros, ones;
  logic [XLEN-1:0]  rot_l, rot_r, bit_clr, bit_set, bit_flip, bit_get;
  logic [XLEN-1:0]  or_comb, reversed;
  logic [XLEN-1:0]  next_res;
  logic             op_known;

  bmu_arith #(.XLEN(XLEN)) u_arith (
    .op(op), .a(rs1), .b(rs2), .scale(scale), .res(arith_res)
  );

  bmu_count #(.XLEN(XLEN)) u_count (
    .a(rs1), .lead_zeros(lead_zeros), .trail_zeros(trail_zeros), .ones(ones)
  );

  bmu_bitpos #(.XLEN(XLEN)) u_bitpos (
    .a(rs1), .idx(rs2[IDX_W-1:0]), .rot_l(rot_l), .rot_r(rot_r),
    .bit_clr(bit_clr), .bit_set(bit_set), .bit_flip(bit_flip), .bit_get(bit_get)
  );

  bmu_bytes #(.XLEN(XLEN)) u_bytes (
    .a(rs1), .or_comb(or_comb), .reversed(reversed)
  );

  assign op_known = (op < OP_W'(NUM_OPS));

  always_comb begin
    case (op)
      OP_LZC:   next_res = {{(XLEN-CNT_W){1'b0}}, lead_zeros};
      OP_TZC:   next_res = {{(XLEN-CNT_W){1'b0}}, trail_zeros};
      OP_POP:   next_res = {{(XLEN-CNT_W){1'b0}}, ones};
      OP_ROTL:  next_res = rot_l;
      OP_ROTR:  next_res = rot_r;
      OP_BYOR:  next_res = or_comb;
      OP_BYREV: next_res = reversed;
      OP_BCLR:  next_res = bit_clr;
      OP_BSET:  next_res = bit_set;
      OP_BFLIP: next_res = bit_flip;
      OP_BGET:  next_res = bit_get;
      default:  next_res = op_known ? arith_res : '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R2
  AST_ZERO_COUNT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_LZC || op == OP_TZC) && rs1 == '0) |=> result == XLEN); // R5
  AST_POP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_POP) |=> result <= XLEN); // R5
  AST_ROT_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_ROTL || op == OP_ROTR) && rs2[IDX_W-1:0] == '0)
      |=> result == $past(rs1)); // R8
  AST_BGET_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_BGET) |=> result[XLEN-1:1] == '0); // R10
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_known) |=> (result == '0 && out_valid)); // R12
endmodule

// File: tb/bitmanip_unit_test.sv
module bitmanip_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op = '0;
  logic [31:0] rs1 = '0;
  logic [31:0] rs2 = '0;
  logic [1:0]  scale = '0;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5679;

  always #4 clk = ~clk;

  bitmanip_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .rs1(rs1),
    .rs2(rs2), .scale(scale), .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] rnd(inout logic [31:0] s);
    s = s ^ (s << 13);
    s = s ^ (s >> 17);
    s = s ^ (s << 5);
    return s;
  endfunction

  function automatic logic [31:0] model(input int code, input logic [31:0] a,
                                        input logic [31:0] b, input int k);
    logic [31:0] r;
    int n;
    int amt;
    amt = int'(b % 32);
    r = '0;
    case (code)
      0:  r = b + a * (32'd1 << k);
      1:  r = a & ~b;
      2:  r = a | ~b;
      3:  r = ~(a ^ b);
      4:  begin n = 0; while (n < 32 && a[31-n] == 1'b0) n++; r = n; end
      5:  begin n = 0; while (n < 32 && a[n] == 1'b0) n++; r = n; end
      6:  begin n = 0; for (int i = 0; i < 32; i++) n += a[i]; r = n; end
      7:  r = ($signed(a) <= $signed(b)) ? a : b;
      8:  r = ($signed(a) >= $signed(b)) ? a : b;
      9:  r = (a <= b) ? a : b;
      10: r = (a >= b) ? a : b;
      11: r = a[7] ? (a | 32'hFFFF_FF00) : (a & 32'hFF);
      12: r = a[15] ? (a | 32'hFFFF_0000) : (a & 32'hFFFF);
      13: r = a & 32'hFFFF;
      14: for (int i = 0; i < 32; i++) r[(i + amt) % 32] = a[i];
      15: for (int i = 0; i < 32; i++) r[i] = a[(i + amt) % 32];
      16: for (int j = 0; j < 4; j++) r[8*j +: 8] = (a[8*j +: 8] != 0) ? 8'hFF : 8'h00;
      17: r = {a[7:0], a[15:8], a[23:16], a[31:24]};
      18: begin r = a; r[amt] = 1'b0; end
      19: begin r = a; r[amt] = 1'b1; end
      20: begin r = a; r[amt] = ~a[amt]; end
      21: r = {31'd0, a[amt]};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic cond, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input int code, input logic [31:0] a,
                     input logic [31:0] b, input int k);
    logic [31:0] exp;
    exp = model(code, a, b, k);
    @(negedge clk);
    in_valid = 1'b1; op = 5'(code); rs1 = a; rs2 = b; scale = 2'(k);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, out_valid === 1'b1, {31'd0, out_valid}, 32'd1);
    check(req, result === exp, result, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] v, a, b, held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", out_valid === 1'b0, {31'd0, out_valid}, 32'd0);
    check("R1", result === 32'd0, result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", out_valid === 1'b0, {31'd0, out_valid}, 32'd0);

    // R3 scaled add, every scale
    for (int k = 0; k < 4; k++) begin
      run("R3", 0, 32'h0000_1234, 32'hFFFF_A988, k);
      run("R3", 0, rnd(seed), rnd(seed), k);
      run("R3", 0, 32'hFFFF_FFFF, 32'h8000_0000, k);
    end

    // R4 inverted logic
    for (int i = 0; i < 20; i++)
      for (int c = 1; c <= 3; c++) run("R4", c, rnd(seed), rnd(seed), 0);

    // R5 counts: all run lengths 0..32
    v = '0;
    for (int i = 0; i <= 32; i++) begin
      run("R5", 4, v, 0, 0);
      run("R5", 6, v, 0, 0);
      v = (v << 1) | 32'd1;
    end
    v = '0;
    for (int i = 0; i <= 32; i++) begin
      run("R5", 5, v, 0, 0);
      v = (v >> 1) | 32'h8000_0000;
    end

    // R6 min/max
    for (int c = 7; c <= 10; c++) begin
      run("R6", c, 32'h8000_0000, 32'h7FFF_FFFF, 0);
      run("R6", c, 32'h7FFF_FFFF, 32'h8000_0000, 0);
      run("R6", c, 32'h5555_5555, 32'h5555_5555, 0);
      for (int i = 0; i < 15; i++) run("R6", c, rnd(seed), rnd(seed), 0);
    end

    // R7 extension
    for (int c = 11; c <= 13; c++) begin
      run("R7", c, 32'h1234_5680, 0, 0);
      run("R7", c, 32'hABCD_807F, 0, 0);
      for (int i = 0; i < 10; i++) run("R7", c, rnd(seed), 0, 0);
    end

    // R8 rotates over every amount
    a = rnd(seed);
    for (int n = 0; n < 32; n++) begin
      run("R8", 14, a, n, 0);
      run("R8", 15, a, n, 0);
    end

    // R9 byte ops with random zeroed lanes
    for (int i = 0; i < 30; i++) begin
      a = rnd(seed);
      b = rnd(seed);
      for (int j = 0; j < 4; j++) if (b[j]) a[8*j +: 8] = 8'h00;
      run("R9", 16, a, 0, 0);
      run("R9", 17, a, 0, 0);
    end
    run("R9", 16, 32'h0100_0080, 0, 0);

    // R10 single-bit ops over every index
    a = rnd(seed);
    for (int n = 0; n < 32; n++)
      for (int c = 18; c <= 21; c++) run("R10", c, a, n, 0);

    // R11 upper index bits ignored
    for (int n = 0; n < 32; n += 7)
      for (int c = 14; c <= 21; c++) begin
        if (c == 16 || c == 17) continue;
        run("R11", c, 32'hC3A5_0F96, 32'hFFFF_FFE0 | n, 0);
        run("R11", c, 32'hC3A5_0F96, 32 + n, 0);
      end

    // R12 unused codes
    for (int c = 22; c < 32; c++) run("R12", c, 32'hFFFF_FFFF, 32'h0000_0003, 3);

    // R2 idle hold with changing inputs
    run("R2", 1, 32'hF0F0_1234, 32'h0F0F_0000, 0);
    held = result;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      op = 5'(i); rs1 = rnd(seed); rs2 = rnd(seed); scale = 2'(i);
      check("R2", out_valid === 1'b0, {31'd0, out_valid}, 32'd0);
      check("R2", result === held, result, held);
    end

    // R1 back-to-back issue
    @(negedge clk);
    in_valid = 1'b1; op = 5'd17; rs1 = 32'h1122_3344;
    @(negedge clk);
    op = 5'd6; rs1 = 32'h0000_00FF;
    check("R1", out_valid === 1'b1, {31'd0, out_valid}, 32'd1);
    check("R1", result === 32'h4433_2211, result, 32'h4433_2211);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", out_valid === 1'b1, {31'd0, out_valid}, 32'd1);
    check("R1", result === 32'd8, result, 32'd8);
    @(negedge clk);
    check("R1", out_valid === 1'b0, {31'd0, out_valid}, 32'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule